// File: doc/BRIEF.md
# Masked burst address counter

This block generates the address for one port of a synchronous memory. An external address is captured into a counter register. The counter then advances by one on each clock to step through a burst of consecutive words. A mask register chooses which low-order bits count. Only those bits take part in the increment, so the mask sets the wrap boundary of the burst. The bits above the mask stay fixed for as long as the burst runs.

A counter-clear input zeroes only the counting bits. A sticky interrupt flag reports each wraparound. A select input drives either the counter or the mask onto a readback bus. Mask bits set to one are counting bits. The mask must be a contiguous run of ones that starts at bit 0.

Top module: `burst_addr_gen`

## Requirements
- R1: When `ads_n` and `cnten_n` are both low at a rising edge (and `cntrst_n` is high), `addr_out` takes the value of `addr_in` after that edge.
- R2: When `cnten_n` is low and `ads_n` is high at a rising edge (and `cntrst_n` is high), the counting bits of `addr_out` increase by one.
- R3: When `cnten_n` is high and `cntrst_n` is high, `addr_out` holds its value.
- R4: With the mask all ones, a step from the top address (all ones) gives address 0.
- R5: When `cntrst_n` is low at a rising edge, the counting bits (mask bit = 1) of `addr_out` become 0 and the other bits keep their value. The wrap flag is not changed.
- R6: During steps, the bits where the mask is 0 never change, and a step from an all-ones counting field gives a counting field of 0.
- R7: A step taken while every counting bit is one is a wrap. It sets `wrap_irq` after that edge, and `wrap_irq` stays set until it is cleared.
- R8: `wrap_irq` clears after an edge where `ack` is high or where a load (R1) takes place. A wrap in the same edge as `ack` leaves the flag set.
- R9: `rb_data` shows the mask when `rb_sel` is 1 and the counter (`addr_out`) when `rb_sel` is 0.
- R10: `mask_ld` high at a rising edge writes `addr_in` into the mask. A step in the same edge still uses the old mask.
- R11: `rst_n` low at a rising edge gives counter 0, mask all ones and `wrap_irq` 0.
- R12: `cntrst_n` low takes priority over a load or a step in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low master reset |
| ads_n | input | 1 | Active-low address strobe (load when counting is enabled) |
| cnten_n | input | 1 | Active-low counter enable |
| cntrst_n | input | 1 | Active-low clear of the counting bits |
| mask_ld | input | 1 | Write the mask from `addr_in` |
| ack | input | 1 | Clear the wrap flag |
| rb_sel | input | 1 | Readback select: 1 = mask, 0 = counter |
| addr_in | input | AW | External address or mask value |
| addr_out | output | AW | Current counter address |
| rb_data | output | AW | Readback of the counter or the mask |
| wrap_irq | output | 1 | Sticky wraparound flag |

## Verification
Two pairs of actions can fall on the same edge, and the bench provokes both. First, a wrapping step arrives together with `ack`. The flag must come out set, because the new wrap outranks the clear. Second, a mask write arrives together with a step. The step must follow the old mask, and the steps after it must follow the new one. The bench judges both cases by checking the counter and the flag one edge later against values it worked out by hand. A counter clear that arrives together with a load is also checked: the clear must win.

// File: rtl/burst_addr_gen_pkg.sv
// Shared types of the masked burst address counter.
package burst_addr_gen_pkg;
    // Action the counter register takes at the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/bag_mask_reg.sv
// Mask register: ones mark the counting bits.
// Assumes software writes only contiguous masks that start at bit 0.
module bag_mask_reg #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] mask_q
);
    // Reset to all ones (full-range counting), otherwise write on ld.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (ld)
            mask_q <= din;
    end
endmodule

// File: rtl/bag_counter.sv
// Address counter: carry is confined to the masked field.
// Assumes a contiguous mask. wrap_evt flags a step taken from an all-ones field.
module bag_counter
    import burst_addr_gen_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_op_e       op,
    input  logic [AW-1:0] din,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] cnt_q,
    output logic          wrap_evt
);
    logic [AW-1:0] stepped;
    logic [AW-1:0] cnt_d;

    // Increment inside the field and keep the fixed bits.
    always_comb begin
        stepped = (cnt_q & ~mask) | ((cnt_q + 1'b1) & mask);
    end

    // Pick the next value from the decoded action.
    always_comb begin
        unique case (op)
            OP_STEP:  cnt_d = stepped;
            OP_LOAD:  cnt_d = din;
            OP_CLEAR: cnt_d = cnt_q & ~mask;
            default:  cnt_d = cnt_q;
        endcase
    end

    // A wrap is a step taken while the whole counting field is ones.
    always_comb begin
        wrap_evt = (op == OP_STEP) && ((cnt_q & mask) == mask);
    end

    // Counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bag_wrap_flag.sv
// Sticky event flag: set wins over clear in the same cycle.
module bag_wrap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold until cleared; a fresh event is never lost.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Top of the masked burst address counter for one memory port.
// Decodes the strobes into one counter action, and drives the readback mux.
// Assumes a contiguous mask and inputs that are synchronous to clk.
module burst_addr_gen
    import burst_addr_gen_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ads_n,
    input  logic          cnten_n,
    input  logic          cntrst_n,
    input  logic          mask_ld,
    input  logic          ack,
    input  logic          rb_sel,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic [AW-1:0] rb_data,
    output logic          wrap_irq
);
    cnt_op_e       op;
    logic [AW-1:0] mask_q;
    logic          wrap_evt;
    logic          flag_clr;

    // Action priority: clear, then load, then step, else hold.
    always_comb begin
        if (!cntrst_n)
            op = OP_CLEAR;
        else if (!cnten_n && !ads_n)
            op = OP_LOAD;
        else if (!cnten_n)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

    // The flag clears on an acknowledge or on a load that takes effect.
    always_comb begin
        flag_clr = ack || (op == OP_LOAD);
    end

    bag_mask_reg #(.AW(AW)) i_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (mask_ld),
        .din    (addr_in),
        .mask_q (mask_q)
    );

    bag_counter #(.AW(AW)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .din      (addr_in),
        .mask     (mask_q),
        .cnt_q    (addr_out),
        .wrap_evt (wrap_evt)
    );

    bag_wrap_flag i_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wrap_evt),
        .clr   (flag_clr),
        .q     (wrap_irq)
    );

    // Readback: the mask or the counter.
    always_comb begin
        rb_data = rb_sel ? mask_q : addr_out;
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker for burst_addr_gen. It is attached with bind and sees the ports and the mask.
module burst_addr_gen_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ads_n,
    input logic          cnten_n,
    input logic          cntrst_n,
    input logic          mask_ld,
    input logic          ack,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] addr_out,
    input logic [AW-1:0] mask_q,
    input logic          wrap_irq
);
    logic step_c;
    logic wrap_c;
    assign step_c = cntrst_n && ads_n && !cnten_n;
    assign wrap_c = step_c && ((addr_out & mask_q) == mask_q);

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cntrst_n && !ads_n && !cnten_n) |=> (addr_out == $past(addr_in)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cntrst_n && cnten_n) |=> $stable(addr_out));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cntrst_n |=> (((addr_out & $past(mask_q)) == '0) &&
                       ((addr_out & ~$past(mask_q)) == ($past(addr_out) & ~$past(mask_q)))));

    p_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_c |=> ((addr_out & ~$past(mask_q)) == ($past(addr_out) & ~$past(mask_q))));

    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_c |=> wrap_irq);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap_c) |=> !wrap_irq);

    p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_ld |=> (mask_q == $past(addr_in)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ads_n    (ads_n),
    .cnten_n  (cnten_n),
    .cntrst_n (cntrst_n),
    .mask_ld  (mask_ld),
    .ack      (ack),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .mask_q   (mask_q),
    .wrap_irq (wrap_irq)
);

// File: tb/test_burst_addr_gen.sv
// Bench for burst_addr_gen: a vector table, then directed reset and corner tests.
module test_burst_addr_gen;
    localparam int AW = 17;
    localparam int NV = 21;

    logic          clk = 1'b0;
    logic          rst_n, ads_n, cnten_n, cntrst_n, mask_ld, ack, rb_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out, rb_data;
    logic          wrap_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.AW(AW)) i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cnten_n(cnten_n),
        .cntrst_n(cntrst_n), .mask_ld(mask_ld), .ack(ack), .rb_sel(rb_sel),
        .addr_in(addr_in), .addr_out(addr_out), .rb_data(rb_data),
        .wrap_irq(wrap_irq)
    );

    // Control field order: {ads_n, cnten_n, cntrst_n, mask_ld, ack}
    // Row: {ctrl[4:0], addr_in[16:0], expected counter[16:0], expected flag}
    localparam logic [39:0] VEC [NV] = '{
        {5'b00100, 17'h1FFFE, 17'h1FFFE, 1'b0}, // R1 load
        {5'b10100, 17'h00000, 17'h1FFFF, 1'b0}, // R2 step
        {5'b10100, 17'h00000, 17'h00000, 1'b1}, // R4 R7 full-range wrap
        {5'b11100, 17'h00000, 17'h00000, 1'b1}, // R3 hold
        {5'b11101, 17'h00000, 17'h00000, 1'b0}, // R8 ack clears
        {5'b11110, 17'h0000F, 17'h00000, 1'b0}, // R10 mask write
        {5'b00100, 17'h00A3E, 17'h00A3E, 1'b0}, // R1 load
        {5'b10100, 17'h00000, 17'h00A3F, 1'b0}, // R2
        {5'b10100, 17'h00000, 17'h00A30, 1'b1}, // R6 field wrap
        {5'b10100, 17'h00000, 17'h00A31, 1'b1}, // R7 sticky
        {5'b11000, 17'h00000, 17'h00A30, 1'b1}, // R5 clear field only
        {5'b00100, 17'h00123, 17'h00123, 1'b0}, // R8 load clears flag
        {5'b00000, 17'h0FFFF, 17'h00120, 1'b0}, // R12 clear beats load
        {5'b00100, 17'h0012E, 17'h0012E, 1'b0},
        {5'b10100, 17'h00000, 17'h0012F, 1'b0},
        {5'b10101, 17'h00000, 17'h00120, 1'b1}, // R8 wrap beats ack
        {5'b11101, 17'h00000, 17'h00120, 1'b0},
        {5'b10110, 17'h00003, 17'h00121, 1'b0}, // R10 step uses old mask
        {5'b10100, 17'h00000, 17'h00122, 1'b0},
        {5'b10100, 17'h00000, 17'h00123, 1'b0},
        {5'b10100, 17'h00000, 17'h00120, 1'b1}  // R6 R10 new mask wrap
    };

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ads_n = 1'b1; cnten_n = 1'b1; cntrst_n = 1'b1;
        mask_ld = 1'b0; ack = 1'b0; addr_in = '0;
    endtask

    initial begin
        rst_n = 1'b0; rb_sel = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        // r11_ reset state
        check("R11 counter", addr_out, '0);
        check("R11 flag", {16'b0, wrap_irq}, '0);
        rb_sel = 1'b1; #1;
        check("R11 mask", rb_data, 17'h1FFFF);
        rb_sel = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ads_n, cnten_n, cntrst_n, mask_ld, ack} = VEC[i][39:35];
            addr_in = VEC[i][34:18];
            @(posedge clk); #1;
            check($sformatf("R1-table row %0d counter", i), addr_out, VEC[i][17:1]);
            check($sformatf("R7-table row %0d flag", i), {16'b0, wrap_irq}, {16'b0, VEC[i][0]});
            check($sformatf("R9 row %0d readback", i), rb_data, VEC[i][17:1]);
        end

        // R9 mask readback
        @(negedge clk); idle(); rb_sel = 1'b1; #1;
        check("R9 mask readback", rb_data, 17'h00003);
        rb_sel = 1'b0;

        // R5 clear with full mask, after resetting the mask via master reset (R11)
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 counter after reset", addr_out, '0);
        check("R11 flag after reset", {16'b0, wrap_irq}, '0);
        rb_sel = 1'b1; #1;
        check("R11 mask after reset", rb_data, 17'h1FFFF);
        rb_sel = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        ads_n = 1'b0; cnten_n = 1'b0; addr_in = 17'h1ABCD;
        @(posedge clk); #1;
        check("R1 load", addr_out, 17'h1ABCD);
        @(negedge clk); idle(); cntrst_n = 1'b0;
        @(posedge clk); #1;
        check("R5 full clear", addr_out, 17'h00000);
        @(negedge clk); idle();
        @(posedge clk); #1;
        check("R3 hold after clear", addr_out, 17'h00000);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule